// File: doc/BRIEF.md
# Boot-Sector Write Protection Controller

This block is the write-permission core of a serial NOR flash with small boot and parameter sectors. It keeps the status byte: a busy flag, a write-enable latch, three block-protect bits and a status-lock bit. Decoded command strobes arrive from the serial front end with a 24-bit address and a data byte. For each one the block answers with an accept or reject flag one cycle later. Accepted program, erase and status-write operations then occupy the device for a self-timed number of clock cycles.

The protect bits select a protected address window. The array is 512 KB, split into two 4 KB sectors, one 8 KB, one 16 KB, one 32 KB and seven 64 KB sectors. A strap input places the small sectors either at address zero (bottom boot) or at the top of the array (top boot). The protected window grows from that end. For an accepted sector erase the block also reports the base address and size of the sector that contains the target address.

Control is a two-state machine. `ST_IDLE` accepts commands. An accepted program, erase or status write takes the GO transition to `ST_BUSY` and loads the busy timer. In `ST_BUSY` only status reads are accepted. When the timer reaches zero, the DONE transition returns to `ST_IDLE` and clears the write-enable latch on the same edge.

Top module: `bootprot_ctrl`

## Requirements
- R1: After reset the status byte reads 00h and no response is pending. Commands use `cmd_op` codes 0 none, 1 write-enable, 2 write-disable, 3 status write, 4 page program, 5 sector erase, 6 chip erase, 7 status read. The response (`resp_valid`, `resp_ok`) and the updated status appear on the clock edge that samples `cmd_valid`.
- R2: The status byte is {lock, 0, 0, bp[2:0], wel, busy}: bit 0 busy, bit 1 write-enable latch, bits 4:2 protect code, bits 6:5 always 0, bit 7 lock. An accepted status write copies only data bits 7, 4, 3 and 2.
- R3: Write-enable sets the latch and write-disable clears it. Both are accepted whenever the device is idle.
- R4: Status write, page program, sector erase and chip erase are rejected while the latch is 0.
- R5: A status write is rejected when lock=1 and `wp_n` is low. When lock=0, `wp_n` has no effect.
- R6: Bottom boot: protect code k in 1..5 protects addresses below 2^(11+k). Code 6 protects below 40000h, code 7 protects everything, and code 0 protects nothing. A program or sector erase aimed into the window is rejected.
- R7: Top boot mirrors R6: code k in 1..5 protects from 80000h-2^(11+k) upward, code 6 protects from 40000h upward, and code 7 protects everything.
- R8: Busy stays high for exactly T_WRSR, T_PROG or T_CE cycles, or for the sector-erase count chosen by sector size (4/8/16/32/64 KB). Busy and the latch fall on the same edge.
- R9: While busy, every command except status read is rejected and changes nothing. Status read is accepted.
- R10: An accepted sector erase outputs the base and size of the sector holding the address in the active orientation. An accepted chip erase outputs base 0 and size 80000h.
- R11: Chip erase is rejected whenever the protect code is nonzero.
- R12: A program or erase whose address has any bit above bit 18 set is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_op | input | 3 | Command code (see R1) |
| cmd_addr | input | 24 | Target address for program and erase |
| cmd_wdata | input | 8 | Data byte for status write |
| wp_n | input | 1 | Active-low write-protect pin |
| top_boot | input | 1 | Orientation strap: 1 places small sectors at the top |
| resp_valid | output | 1 | Response present for the previous command |
| resp_ok | output | 1 | 1 = accepted, 0 = rejected |
| status_o | output | 8 | Status byte (see R2) |
| erase_base | output | 24 | Base address of the last accepted erase |
| erase_size | output | 24 | Size in bytes of the last accepted erase |

## Verification
The embedded properties guard these rules on every cycle: rejection while busy, rejection without the latch, the status-write lock, rejection of program or erase into a window flagged by the range decoder, reserved bits reading zero, the latch being clear whenever busy falls, sector alignment, and the timer only being reloaded at zero. The bench scenarios are needed for everything else. That covers the exact window boundaries in both orientations, the cycle count of each busy period, the written status value, and the concrete base and size reported for each sector.

// File: rtl/bootprot_pkg.sv
package bootprot_pkg;
    typedef enum logic [2:0] {
        OP_NOP    = 3'd0,
        OP_WREN   = 3'd1,
        OP_WRDI   = 3'd2,
        OP_WRSR   = 3'd3,
        OP_PROG   = 3'd4,
        OP_SERASE = 3'd5,
        OP_CERASE = 3'd6,
        OP_RDSR   = 3'd7
    } op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } state_e;

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/bootprot_sector_map.sv
module bootprot_sector_map #(
    parameter int ARRAY_AW  = 19,
    parameter int SMALL_LOG = 12
) (
    input  logic [ARRAY_AW-1:0] addr,
    input  logic                top_boot,
    output logic [ARRAY_AW-1:0] base,
    output logic [ARRAY_AW-1:0] size,
    output logic [2:0]          size_code
);
    localparam int BIG_LOG = SMALL_LOG + 4;
    localparam logic [ARRAY_AW-1:0] ONE = 1;

    logic [ARRAY_AW-1:0] m;
    logic [ARRAY_AW-1:0] mbase;
    logic [ARRAY_AW-1:0] last;

    always_comb begin
        // Fold top boot onto the bottom-boot layout by mirroring the address.
        m = top_boot ? ~addr : addr;
        size_code = 3'd0;
        for (int i = 1; i <= 3; i++) begin
            if (m[SMALL_LOG+i]) size_code = 3'(i);
        end
        if (|m[ARRAY_AW-1:BIG_LOG]) size_code = 3'd4;
        size  = ONE << (SMALL_LOG + int'(size_code));
        mbase = m & ~(size - ONE);
        last  = mbase + size - ONE;
        base  = top_boot ? ~last : mbase;
    end
endmodule

// File: rtl/bootprot_protect.sv
module bootprot_protect #(
    parameter int ARRAY_AW  = 19,
    parameter int SMALL_LOG = 12
) (
    input  logic [ARRAY_AW-1:0] addr,
    input  logic                top_boot,
    input  logic [2:0]          bp,
    output logic                hit
);
    localparam logic [ARRAY_AW:0] ONE = 1;

    logic [ARRAY_AW-1:0] m;
    logic [ARRAY_AW:0]   limit;

    always_comb begin
        m = top_boot ? ~addr : addr;
        unique case (bp)
            3'd0:    limit = '0;
            3'd6:    limit = ONE << (ARRAY_AW - 1);
            3'd7:    limit = ONE << ARRAY_AW;
            default: limit = ONE << (SMALL_LOG - 1 + int'(bp));
        endcase
        hit = ({1'b0, m} < limit);
    end
endmodule

// File: rtl/bootprot_busy_timer.sv
module bootprot_busy_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cnt <= '0;
        else if (load)      cnt <= load_val;
        else if (cnt != '0) cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    // R8: a new busy period never starts on top of a running one
    assert_reload_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> zero);
endmodule

// File: rtl/bootprot_ctrl.sv
module bootprot_ctrl
    import bootprot_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int ARRAY_AW  = 19,
    parameter int SMALL_LOG = 12,
    parameter int T_WRSR    = 5,
    parameter int T_PROG    = 8,
    parameter int T_SE_4K   = 10,
    parameter int T_SE_8K   = 12,
    parameter int T_SE_16K  = 14,
    parameter int T_SE_32K  = 16,
    parameter int T_SE_64K  = 20,
    parameter int T_CE      = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [7:0]        cmd_wdata,
    input  logic              wp_n,
    input  logic              top_boot,
    output logic              resp_valid,
    output logic              resp_ok,
    output logic [7:0]        status_o,
    output logic [ADDR_W-1:0] erase_base,
    output logic [ADDR_W-1:0] erase_size
);
    localparam int T_MAX = max_int(max_int(max_int(T_WRSR, T_PROG), max_int(T_CE, T_SE_64K)),
                                   max_int(max_int(T_SE_4K, T_SE_8K), max_int(T_SE_16K, T_SE_32K)));
    localparam int CNT_W = $clog2(T_MAX + 1);
    localparam logic [ADDR_W-1:0] ARRAY_BYTES = ADDR_W'(1) << ARRAY_AW;

    op_e    op;
    state_e state, state_nx;

    logic       srp, wel;
    logic [2:0] bp;
    logic       busy, lock, prot_hit, out_of_range, is_mut, ok, go, t_zero;
    logic [ARRAY_AW-1:0] sec_base, sec_size;
    logic [2:0]          sec_code;
    logic [CNT_W-1:0]    dur;
    logic                unused_wdata;

    assign op           = op_e'(cmd_op);
    assign busy         = (state == ST_BUSY);
    assign lock         = srp & ~wp_n;
    assign out_of_range = |cmd_addr[ADDR_W-1:ARRAY_AW];
    assign unused_wdata = ^{cmd_wdata[6:5], cmd_wdata[1:0]};
    assign status_o     = {srp, 2'b00, bp, wel, busy};

    bootprot_sector_map #(.ARRAY_AW(ARRAY_AW), .SMALL_LOG(SMALL_LOG)) u_map (
        .addr(cmd_addr[ARRAY_AW-1:0]), .top_boot(top_boot),
        .base(sec_base), .size(sec_size), .size_code(sec_code));

    bootprot_protect #(.ARRAY_AW(ARRAY_AW), .SMALL_LOG(SMALL_LOG)) u_prot (
        .addr(cmd_addr[ARRAY_AW-1:0]), .top_boot(top_boot), .bp(bp), .hit(prot_hit));

    bootprot_busy_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(go), .load_val(dur - 1'b1), .zero(t_zero));

    // Acceptance decision
    always_comb begin
        is_mut = 1'b0;
        unique case (op)
            OP_RDSR:            ok = 1'b1;
            OP_WREN, OP_WRDI:   ok = !busy;
            OP_WRSR: begin
                is_mut = 1'b1;
                ok = !busy && wel && !lock;
            end
            OP_PROG, OP_SERASE: begin
                is_mut = 1'b1;
                ok = !busy && wel && !prot_hit && !out_of_range;
            end
            OP_CERASE: begin
                is_mut = 1'b1;
                ok = !busy && wel && (bp == 3'd0);
            end
            default:            ok = 1'b0;
        endcase
        go = cmd_valid && ok && is_mut;
    end

    // Busy duration per operation
    always_comb begin
        unique case (op)
            OP_WRSR:   dur = CNT_W'(T_WRSR);
            OP_PROG:   dur = CNT_W'(T_PROG);
            OP_CERASE: dur = CNT_W'(T_CE);
            OP_SERASE: begin
                unique case (sec_code)
                    3'd0:    dur = CNT_W'(T_SE_4K);
                    3'd1:    dur = CNT_W'(T_SE_8K);
                    3'd2:    dur = CNT_W'(T_SE_16K);
                    3'd3:    dur = CNT_W'(T_SE_32K);
                    default: dur = CNT_W'(T_SE_64K);
                endcase
            end
            default:   dur = CNT_W'(1);
        endcase
    end

    // Next state: GO (IDLE->BUSY), DONE (BUSY->IDLE)
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (go)     state_nx = ST_BUSY;
            ST_BUSY: if (t_zero) state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Status, response and erase-range registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            srp        <= 1'b0;
            bp         <= 3'd0;
            wel        <= 1'b0;
            resp_valid <= 1'b0;
            resp_ok    <= 1'b0;
            erase_base <= '0;
            erase_size <= '0;
        end else begin
            resp_valid <= cmd_valid && (op != OP_NOP);
            resp_ok    <= cmd_valid && ok;
            if (busy && t_zero) wel <= 1'b0;
            if (cmd_valid && ok) begin
                unique case (op)
                    OP_WREN: wel <= 1'b1;
                    OP_WRDI: wel <= 1'b0;
                    OP_WRSR: begin
                        srp <= cmd_wdata[7];
                        bp  <= cmd_wdata[4:2];
                    end
                    OP_SERASE: begin
                        erase_base <= ADDR_W'(sec_base);
                        erase_size <= ADDR_W'(sec_size);
                    end
                    OP_CERASE: begin
                        erase_base <= '0;
                        erase_size <= ARRAY_BYTES;
                    end
                    default: ;
                endcase
            end
        end
    end

    // Embedded checks
    logic [ARRAY_AW:0] chk_base, chk_size, chk_addr;
    assign chk_base = {1'b0, sec_base};
    assign chk_size = {1'b0, sec_size};
    assign chk_addr = {1'b0, cmd_addr[ARRAY_AW-1:0]};

    assert_busy_rejects_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_valid && op != OP_RDSR && op != OP_NOP) |=> (resp_valid && !resp_ok));

    assert_needs_wel_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && is_mut && !status_o[1]) |=> !resp_ok);

    assert_sr_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && op == OP_WRSR && status_o[7] && !wp_n) |=> !resp_ok);

    assert_protected_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (op == OP_PROG || op == OP_SERASE) && prot_hit) |=> !resp_ok);

    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[6:5] == 2'b00);

    assert_wel_with_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status_o[0]) |-> !status_o[1]);

    assert_sector_fit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (((chk_base & (chk_size - 1'b1)) == '0) && (chk_addr - chk_base < chk_size)));
endmodule

// File: tb/bootprot_ctrl_bench.sv
module bootprot_ctrl_bench;
    import bootprot_pkg::*;

    localparam int T_WRSR = 5, T_PROG = 8, T_CE = 30;
    localparam int T_SE_4K = 10, T_SE_8K = 12, T_SE_16K = 14, T_SE_64K = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic [23:0] cmd_addr = '0;
    logic [7:0]  cmd_wdata = '0;
    logic        wp_n = 1'b1;
    logic        top_boot = 1'b0;
    logic        resp_valid, resp_ok;
    logic [7:0]  status_o;
    logic [23:0] erase_base, erase_size;

    int n_chk = 0;
    int n_err = 0;
    bit    exp_q[$];
    string tag_q[$];

    always #2 clk = ~clk;

    bootprot_ctrl u_bootprot_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .wp_n(wp_n), .top_boot(top_boot),
        .resp_valid(resp_valid), .resp_ok(resp_ok), .status_o(status_o),
        .erase_base(erase_base), .erase_size(erase_size));

    task automatic check(input bit good, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!good) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Monitor: pops the expected response for every response produced
    always @(negedge clk) begin
        if (rst_n && resp_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R1", "unexpected response", 1, 0);
            end else begin
                automatic bit    e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(resp_ok == e, t, "accept flag", int'(resp_ok), int'(e));
            end
        end
    end

    // Driver: one command, expected result pushed into the scoreboard
    task automatic issue(input op_e op, input logic [23:0] a, input logic [7:0] d,
                         input bit exp_ok, input string tag);
        @(negedge clk);
        exp_q.push_back(exp_ok);
        tag_q.push_back(tag);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = d;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd0;
    endtask

    task automatic busy_len(output int n);
        n = 0;
        while (status_o[0] && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic set_bp(input logic [2:0] b, input string tag);
        int n;
        issue(OP_WREN, '0, '0, 1'b1, tag);
        issue(OP_WRSR, '0, {3'b000, b, 2'b00}, 1'b1, tag);
        busy_len(n);
    endtask

    task automatic try_prog(input logic [23:0] a, input bit exp_ok, input string tag);
        int n;
        issue(OP_WREN, '0, '0, 1'b1, tag);
        issue(OP_PROG, a, '0, exp_ok, tag);
        busy_len(n);
    endtask

    task automatic try_erase(input logic [23:0] a, input int eb, input int es,
                             input int ecyc, input string tag);
        int n;
        issue(OP_WREN, '0, '0, 1'b1, tag);
        issue(OP_SERASE, a, '0, 1'b1, tag);
        check(erase_base == eb, "R10", "erase base", int'(erase_base), eb);
        check(erase_size == es, "R10", "erase size", int'(erase_size), es);
        busy_len(n);
        check(n == ecyc, "R8", "sector erase busy cycles", n, ecyc);
    endtask

    function automatic int win(input int b);
        if (b == 6) return 32'h40000;
        return 1 << (11 + b);
    endfunction

    bit finished = 1'b0;

    initial begin
        #(4 * 150000);
        if (!finished) begin
            check(1'b0, "R1", "watchdog expired", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(status_o == 8'h00, "R1", "reset status", status_o, 8'h00);
        check(resp_valid == 1'b0, "R1", "reset response", resp_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4: status write without the latch
        issue(OP_WRSR, '0, 8'hFF, 1'b0, "R4");
        check(status_o == 8'h00, "R4", "status after rejected write", status_o, 8'h00);

        // R3: latch set and clear
        issue(OP_WREN, '0, '0, 1'b1, "R3");
        check(status_o == 8'h02, "R3", "latch set", status_o, 8'h02);
        issue(OP_WRDI, '0, '0, 1'b1, "R3");
        check(status_o == 8'h00, "R3", "latch clear", status_o, 8'h00);

        // R2/R8: write all ones, only bits 7,4,3,2 stick
        issue(OP_WREN, '0, '0, 1'b1, "R2");
        issue(OP_WRSR, '0, 8'hFF, 1'b1, "R2");
        check(status_o == 8'h9F, "R2", "status while writing", status_o, 8'h9F);
        busy_len(n);
        check(n == T_WRSR, "R8", "status write busy cycles", n, T_WRSR);
        check(status_o == 8'h9C, "R2", "status after write", status_o, 8'h9C);

        // R5: lock with wp_n low, release with wp_n high
        wp_n = 1'b0;
        issue(OP_WREN, '0, '0, 1'b1, "R5");
        issue(OP_WRSR, '0, 8'h00, 1'b0, "R5");
        check(status_o == 8'h9E, "R5", "locked status unchanged", status_o, 8'h9E);
        wp_n = 1'b1;
        issue(OP_WRSR, '0, 8'h00, 1'b1, "R5");
        busy_len(n);
        check(status_o == 8'h00, "R5", "unlocked write", status_o, 8'h00);
        wp_n = 1'b0;
        set_bp(3'd1, "R5");
        check(status_o == 8'h04, "R5", "wp_n ignored with lock clear", status_o, 8'h04);
        wp_n = 1'b1;

        // R9: busy blocks all but status read
        issue(OP_WREN, '0, '0, 1'b1, "R9");
        issue(OP_PROG, 24'h040000, '0, 1'b1, "R9");
        issue(OP_WRDI, '0, '0, 1'b0, "R9");
        issue(OP_RDSR, '0, '0, 1'b1, "R9");
        check(status_o == 8'h07, "R9", "status while busy", status_o, 8'h07);
        busy_len(n);
        check(status_o == 8'h04, "R8", "latch cleared after program", status_o, 8'h04);

        // R6: bottom-boot window edges, program and erase
        issue(OP_WREN, '0, '0, 1'b1, "R6");
        issue(OP_SERASE, 24'h000800, '0, 1'b0, "R6");
        issue(OP_WRDI, '0, '0, 1'b1, "R6");
        for (int b = 1; b <= 7; b++) begin
            set_bp(3'(b), "R6");
            if (b == 7) begin
                try_prog(24'h07FFFF, 1'b0, "R6");
            end else begin
                try_prog(24'(win(b) - 1), 1'b0, "R6");
                try_prog(24'(win(b)), 1'b1, "R6");
            end
        end

        // R7: top-boot mirrored window edges
        top_boot = 1'b1;
        for (int b = 1; b <= 7; b++) begin
            set_bp(3'(b), "R7");
            if (b == 7) begin
                try_prog(24'h000000, 1'b0, "R7");
            end else begin
                try_prog(24'(32'h80000 - win(b)), 1'b0, "R7");
                try_prog(24'(32'h80000 - win(b) - 1), 1'b1, "R7");
            end
        end

        // R11: chip erase blocked by any protection
        set_bp(3'd1, "R11");
        issue(OP_WREN, '0, '0, 1'b1, "R11");
        issue(OP_CERASE, '0, '0, 1'b0, "R11");
        check(status_o[0] == 1'b0, "R11", "no busy after rejected chip erase", status_o[0], 0);

        // R10/R8: sector lookup and per-size erase time
        set_bp(3'd0, "R10");
        try_erase(24'h07FF00, 32'h7F000, 32'h1000, T_SE_4K, "R10");
        try_erase(24'h07A000, 32'h78000, 32'h4000, T_SE_16K, "R10");
        top_boot = 1'b0;
        try_erase(24'h002345, 32'h2000, 32'h2000, T_SE_8K, "R10");
        try_erase(24'h012345, 32'h10000, 32'h10000, T_SE_64K, "R10");

        // R12: address beyond the array
        try_prog(24'h080000, 1'b0, "R12");
        issue(OP_WRDI, '0, '0, 1'b1, "R12");

        // R10/R8: chip erase range and time
        issue(OP_WREN, '0, '0, 1'b1, "R10");
        issue(OP_CERASE, '0, '0, 1'b1, "R10");
        check(erase_base == 0, "R10", "chip erase base", int'(erase_base), 0);
        check(erase_size == 24'h080000, "R10", "chip erase size", int'(erase_size), 32'h80000);
        busy_len(n);
        check(n == T_CE, "R8", "chip erase busy cycles", n, T_CE);
        check(status_o == 8'h00, "R8", "status after chip erase", status_o, 8'h00);

        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R1", "responses outstanding", exp_q.size(), 0);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule